// File: doc/BRIEF.md
# Microsecond Event Timer

The block is a programmable down-counting event timer. It advances on a one-microsecond tick enable that a separate timebase supplies. Software arms it through a single control word. That word carries a run flag, a repeat flag and a reload value. To get an expiry after N ticks, software loads N-1, so a loaded value of 0 expires on the very next tick.

When the count has reached zero and a further tick arrives, the timer raises a level-high interrupt. In single-shot operation the run flag then drops and the timer halts. In repeat operation the reload value is copied back into the count and the timer keeps going. The interrupt stays high until software writes an acknowledge word with the acknowledge bit set. Writing the control word at any time restarts the timer at once, and writing an all-zero word stops it.

The tick source, the interrupt controller and the register bus lie outside the block. The bus reaches the block as two write strobes with data and two read-data outputs.

Top module: `usec_event_timer`

## Requirements
- R1: In the control word, bit 31 is the run flag, bit 30 is the repeat flag and bits [28:0] are the reload value, up to 0x1FFFFFFF. Bit 29 is ignored. The control readback returns {run, repeat, 0, reload value}.
- R2: Loading value N-1 with the run flag set raises `irq` on the Nth tick. `irq` is high in the cycle after that tick's clock edge. A value of 0 expires on the first tick.
- R3: While the run flag is clear, ticks leave the count unchanged and raise no interrupt. A control write with bit 31 at 0, including an all-zero word, stops the timer.
- R4: In single-shot operation (bit 30 at 0), the run flag clears itself at expiry and the count stays at 0. Later ticks raise no new interrupt.
- R5: In repeat operation (bit 30 at 1), expiry reloads the count with the reload value and the run flag stays set. The timer then expires every reload+1 ticks.
- R6: `irq` is level-high and stays set until an acknowledge write with bit 30 at 1. An acknowledge write with bit 30 at 0 has no effect.
- R7: The count readback returns the live remaining count in bits [28:0], with bits [31:29] at zero. While running, the count drops by one on each tick and holds between ticks.
- R8: A control write restarts the timer in that same cycle with the new value and operation. The count readback equals the written value in the next cycle, and a tick in the write cycle is discarded.
- R9: When an expiry and an acknowledge write fall in the same cycle, `irq` ends that cycle set.
- R10: After reset the control readback, the count readback and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-microsecond tick enable, one clock wide |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: run, repeat, reload value |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_wdata | input | 32 | Acknowledge word; bit 30 clears the interrupt |
| ctl_rdata | output | 32 | Control word readback |
| cnt_rdata | output | 32 | Live count readback |
| irq | output | 1 | Level-high expiry interrupt |

## Verification
The timer is driven with sparse ticks, one every few clocks. This keeps the decrement-per-tick behaviour apart from any per-clock decrement. Single-shot loads of 4 and 0 count the ticks up to the interrupt, which exposes off-by-one faults in the N-1 convention. Repeat loads measure two consecutive periods, which separates reload from halt. Control writes are placed on the same cycle as a tick, and acknowledge writes on the same cycle as an expiry. These placements fix the restart and set-over-clear priorities. Acknowledge words with bit 30 clear, and ticks on a stopped timer, confirm that those inputs leave the observable state untouched.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;

   // Action the counter requests from the control register on a tick
   typedef enum logic [1:0] {
      EXP_NONE   = 2'd0,
      EXP_RELOAD = 2'd1,
      EXP_HALT   = 2'd2
   } expiry_e;

endpackage

// File: rtl/utm_arm_ctrl.sv
module utm_arm_ctrl
   import usec_timer_pkg::*;
#(
   parameter int CNT_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_run,
   input  logic             load_rep,
   input  logic [CNT_W-1:0] load_val,
   input  expiry_e          exp_act,
   output logic             run,
   output logic             rep,
   output logic [CNT_W-1:0] reload_val
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run        <= 1'b0;
         rep        <= 1'b0;
         reload_val <= '0;
      end else if (load) begin
         run        <= load_run;
         rep        <= load_rep;
         reload_val <= load_val;
      end else if (exp_act == EXP_HALT) begin
         run <= 1'b0;
      end
   end

   // R5: a repeat expiry leaves the run flag set
   p_rep_keeps_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_act == EXP_RELOAD && !load) |=> run);

endmodule

// File: rtl/utm_down_counter.sv
module utm_down_counter
   import usec_timer_pkg::*;
#(
   parameter int CNT_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             rep,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output expiry_e          exp_act
);

   logic at_zero;
   logic step;

   assign at_zero = (count == '0);
   assign step    = tick && run && !load;

   always_comb begin
      exp_act = EXP_NONE;
      if (step && at_zero) begin
         exp_act = rep ? EXP_RELOAD : EXP_HALT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (step) begin
         if (!at_zero) begin
            count <= count - CNT_W'(1);
         end else if (rep) begin
            count <= reload_val;
         end
      end
   end

   // R7: one decrement per tick while running
   p_dec_per_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !load && count != '0) |=> (count == $past(count) - CNT_W'(1)));

   // R7: no tick, no load -> count holds
   p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(count));

endmodule

// File: rtl/utm_irq_latch.sv
module utm_irq_latch #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq
);

   generate
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   irq <= 1'b0;
            else if (set) irq <= 1'b1;
            else if (clr) irq <= 1'b0;
         end

         // R9: an expiry beats a simultaneous acknowledge
         p_set_beats_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set |=> irq);
      end else begin : g_clr_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   irq <= 1'b0;
            else if (clr) irq <= 1'b0;
            else if (set) irq <= 1'b1;
         end

         p_clr_beats_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> !irq);
      end
   endgenerate

   // R6: level interrupt stays until acknowledged
   p_irq_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr) |=> irq);

endmodule

// File: rtl/usec_event_timer.sv
module usec_event_timer
   import usec_timer_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 29,
   parameter int RUN_BIT  = 31,
   parameter int REP_BIT  = 30,
   parameter int ACK_BIT  = 30,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_wdata,
   input  logic              ack_wr,
   input  logic [DATA_W-1:0] ack_wdata,
   output logic [DATA_W-1:0] ctl_rdata,
   output logic [DATA_W-1:0] cnt_rdata,
   output logic              irq
);

   localparam int PAD_W = DATA_W - CNT_W;

   // Elaboration-time parameter checks
   generate
      if (CNT_W < 1 || PAD_W < 2) begin : g_bad_width
         $error("usec_event_timer: CNT_W must leave room for the flag bits");
      end
      if (RUN_BIT < CNT_W || RUN_BIT >= DATA_W || REP_BIT < CNT_W || REP_BIT >= DATA_W) begin : g_bad_flag
         $error("usec_event_timer: flag bits must sit above the count field");
      end
      if (RUN_BIT == REP_BIT) begin : g_flag_clash
         $error("usec_event_timer: run and repeat flags must differ");
      end
      if (ACK_BIT >= DATA_W) begin : g_bad_ack
         $error("usec_event_timer: acknowledge bit out of range");
      end
   endgenerate

   logic             run;
   logic             rep;
   logic [CNT_W-1:0] reload_val;
   logic [CNT_W-1:0] count;
   expiry_e          exp_act;
   logic             ack_hit;
   logic             unused_wbits;

   assign ack_hit      = ack_wr && ack_wdata[ACK_BIT];
   assign unused_wbits = ^{ctl_wdata, ack_wdata};

   utm_arm_ctrl #(.CNT_W(CNT_W)) u_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (ctl_wr),
      .load_run   (ctl_wdata[RUN_BIT]),
      .load_rep   (ctl_wdata[REP_BIT]),
      .load_val   (ctl_wdata[CNT_W-1:0]),
      .exp_act    (exp_act),
      .run        (run),
      .rep        (rep),
      .reload_val (reload_val)
   );

   utm_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .run        (run),
      .rep        (rep),
      .reload_val (reload_val),
      .load       (ctl_wr),
      .load_val   (ctl_wdata[CNT_W-1:0]),
      .count      (count),
      .exp_act    (exp_act)
   );

   utm_irq_latch #(.SET_WINS(SET_WINS)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (exp_act != EXP_NONE),
      .clr   (ack_hit),
      .irq   (irq)
   );

   always_comb begin
      ctl_rdata              = '0;
      ctl_rdata[RUN_BIT]     = run;
      ctl_rdata[REP_BIT]     = rep;
      ctl_rdata[CNT_W-1:0]   = reload_val;
   end

   assign cnt_rdata = {{PAD_W{1'b0}}, count};

   // R3: a stopped timer keeps its count
   p_stopped_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_rdata[RUN_BIT] && !ctl_wr) |=> $stable(cnt_rdata));

   // R3: a stopped timer raises no new interrupt
   p_stopped_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_rdata[RUN_BIT] && !ctl_wr && !irq) |=> !irq);

   // R4: single-shot expiry drops the run flag
   p_oneshot_halts_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[RUN_BIT] && !ctl_rdata[REP_BIT] && tick && !ctl_wr && cnt_rdata == '0)
      |=> !ctl_rdata[RUN_BIT]);

   // R5: repeat expiry reloads the count
   p_repeat_reloads_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[RUN_BIT] && ctl_rdata[REP_BIT] && tick && !ctl_wr && cnt_rdata == '0)
      |=> (cnt_rdata[CNT_W-1:0] == ctl_rdata[CNT_W-1:0]));

   // R8: a control write restarts the count at once
   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (cnt_rdata[CNT_W-1:0] == $past(ctl_wdata[CNT_W-1:0])));

   // R7: upper count readback bits stay zero
   p_cnt_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rdata[DATA_W-1:CNT_W] == '0);

endmodule

// File: tb/usec_event_timer_tb.sv
module usec_event_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic        ack_wr = 1'b0;
   logic [31:0] ack_wdata = '0;
   logic [31:0] ctl_rdata;
   logic [31:0] cnt_rdata;
   logic        irq;

   integer n_chk = 0;
   integer n_fail = 0;
   integer cyc = 0;

   // Behavioural reference state
   bit          m_run = 0, m_rep = 0, m_irq = 0;
   longint      m_val = 0, m_cnt = 0;

   always #5 clk = ~clk;

   usec_event_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .ack_wr    (ack_wr),
      .ack_wdata (ack_wdata),
      .ctl_rdata (ctl_rdata),
      .cnt_rdata (cnt_rdata),
      .irq       (irq)
   );

   task automatic check(input longint act, input longint exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // Reference model: advances on each rising edge from the driven inputs
   always @(posedge clk) begin
      bit fired;
      fired = 0;
      if (!rst_n) begin
         m_run = 0; m_rep = 0; m_val = 0; m_cnt = 0; m_irq = 0;
      end else begin
         if (ctl_wr) begin
            m_run = ctl_wdata[31];
            m_rep = ctl_wdata[30];
            m_val = ctl_wdata & 32'h1FFF_FFFF;
            m_cnt = m_val;
         end else if (tick && m_run) begin
            if (m_cnt > 0) m_cnt = m_cnt - 1;
            else begin
               fired = 1;
               if (m_rep) m_cnt = m_val;
               else m_run = 0;
            end
         end
         if (fired) m_irq = 1;
         else if (ack_wr && ack_wdata[30]) m_irq = 0;
      end
   end

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      check(ctl_rdata, {m_run, m_rep, 1'b0, m_val[28:0]}, "R1 control readback vs model");
      check(cnt_rdata, m_cnt, "R7 count readback vs model");
      check(irq, m_irq, "R6 irq vs model");
   end

   // Watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic drive(input bit t, input bit cw, input logic [31:0] cd,
                        input bit aw, input logic [31:0] ad);
      @(negedge clk);
      tick = t; ctl_wr = cw; ctl_wdata = cd; ack_wr = aw; ack_wdata = ad;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
   endtask

   // One tick followed by two quiet cycles; returns at a sampling point
   task automatic one_tick();
      drive(1, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0);
   endtask

   task automatic write_ctl(input logic [31:0] d);
      drive(0, 1, d, 0, 0);
      drive(0, 0, 0, 0, 0);
   endtask

   task automatic ack(input logic [31:0] d);
      drive(0, 0, 0, 1, d);
      drive(0, 0, 0, 0, 0);
   endtask

   task automatic ticks_to_irq(input int limit, output int n);
      n = -1;
      for (int i = 1; i <= limit; i++) begin
         one_tick();
         if (irq) begin
            n = i;
            break;
         end
      end
   endtask

   initial begin
      int n;
      idle(3);
      // R10: reset state
      check(ctl_rdata, 0, "R10 control after reset");
      check(cnt_rdata, 0, "R10 count after reset");
      check(irq, 0, "R10 irq after reset");
      drive(0, 0, 0, 0, 0);
      rst_n = 1'b1;
      idle(2);

      // R1: bit 29 ignored, flags placed at 31/30
      write_ctl(32'hE000_0005);
      check(ctl_rdata, 32'hC000_0005, "R1 bit29 dropped");
      write_ctl(32'h9FFF_FFFF);
      check(ctl_rdata, 32'h9FFF_FFFF, "R1 max value readback");
      check(cnt_rdata, 32'h1FFF_FFFF, "R7 max count upper bits zero");
      write_ctl(32'h0);

      // R2 / R4: single-shot, value 4 -> 5 ticks
      write_ctl(32'h8000_0004);
      ticks_to_irq(10, n);
      check(n, 5, "R2 ticks to expiry for value 4");
      check(ctl_rdata[31], 0, "R4 run flag cleared at expiry");
      check(cnt_rdata, 0, "R4 count stays zero");
      // R6: level held, bad ack ignored, good ack clears
      idle(5);
      check(irq, 1, "R6 irq held");
      ack(32'hBFFF_FFFF);
      check(irq, 1, "R6 ack without bit30 ignored");
      ack(32'h4000_0000);
      check(irq, 0, "R6 ack clears irq");
      for (int i = 0; i < 3; i++) one_tick();
      check(irq, 0, "R4 no further expiry");

      // R2: value 0 expires on first tick
      write_ctl(32'h8000_0000);
      ticks_to_irq(4, n);
      check(n, 1, "R2 value 0 first tick");
      ack(32'h4000_0000);

      // R5: repeat with value 2 -> period of 3 ticks
      write_ctl(32'hC000_0002);
      ticks_to_irq(8, n);
      check(n, 3, "R5 first period");
      check(cnt_rdata, 2, "R5 reload after expiry");
      ack(32'h4000_0000);
      ticks_to_irq(8, n);
      check(n, 3, "R5 second period");
      check(ctl_rdata[31], 1, "R5 run flag kept");
      ack(32'h4000_0000);

      // R3: stopped timer with value loaded
      write_ctl(32'h0000_0007);
      for (int i = 0; i < 4; i++) one_tick();
      check(cnt_rdata, 7, "R3 stopped count holds");
      check(irq, 0, "R3 stopped no irq");
      write_ctl(32'h8000_0010);
      one_tick(); one_tick();
      write_ctl(32'h0);
      for (int i = 0; i < 20; i++) one_tick();
      check(irq, 0, "R3 zero write stops");

      // R7 / R8: decrement, then restart on a tick cycle
      write_ctl(32'h8000_0064);
      for (int i = 0; i < 3; i++) one_tick();
      check(cnt_rdata, 32'h61, "R7 three decrements");
      drive(1, 1, 32'hC000_0003, 0, 0);
      drive(0, 0, 0, 0, 0);
      check(cnt_rdata, 3, "R8 restart value, tick discarded");
      check(ctl_rdata, 32'hC000_0003, "R8 new operation");
      ticks_to_irq(8, n);
      check(n, 4, "R8 new period");
      ack(32'h4000_0000);

      // R9: expiry and ack in the same cycle
      write_ctl(32'hC000_0001);
      one_tick();
      drive(1, 0, 0, 1, 32'h4000_0000);
      drive(0, 0, 0, 0, 0);
      check(irq, 1, "R9 expiry beats ack");

      idle(4);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule